// File: doc/BRIEF.md
# Recall Line-Signal Timer

This block generates the line signalling for a telephone recall press. A debounced recall key level arrives together with a millisecond tick. The block measures how many ticks the key stays down. It then drives a ground-loop pulse, a loop-break (flash) request, or both. When those pulses are finished, it starts the fixed speech pause that always follows a recall. The pulse length comes from the hold time, so a short press and a long press give different ground-loop pulses. While a redial is running, the long pulse is always used.

Which signals fire is set by a two-bit configuration code and by the signalling mode. In pulse-dialling (LD) mode no flash is ever produced. The block treats one recall as a whole: the press, the pulse phase and the pause. Further presses are ignored until that sequence has ended and the key has been released and pressed again.

Top module: `recall_signal_gen`

## Requirements
- R1: If the key is held for 540 ticks or fewer, then gl_out goes high without a gap for exactly 500 ticks. Hold time is the number of ms_tick pulses seen while the key stays high, counted from the cycle after the press is detected.
- R2: If the key is held for more than 540 ticks, gl_out goes high for exactly 1250 ticks. The pulse starts as soon as tick 541 has been counted, even if the key is still down.
- R3: If redial_active is high when the pulse is chosen, the ground-loop pulse is 1250 ticks whatever the hold time.
- R4: recall_cfg 2'b01 selects flash only and 2'b10 selects ground loop only. 2'b00 and 2'b11 mean "unset", and then both signals are issued together.
- R5: When mode_mf is 0 (LD), flash_out never rises, whatever the configuration.
- R6: After each recall, once gl_out and flash_out are both low, pause_start is high for exactly one cycle. The block then spends 3000 ticks in the pause before it accepts a new press.
- R7: A flash holds flash_out high for exactly 100 ticks.
- R8: A press that arrives during the hold, pulse or pause phases is ignored. A key that is still held when the pause ends does not start a recall; only a new rising edge does.
- R9: While reset is active and right after it, gl_out, flash_out and pause_start are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| recall_key | input | 1 | Debounced recall key level, high while pressed |
| mode_mf | input | 1 | 1 = tone (MF) signalling, 0 = pulse (LD) signalling |
| recall_cfg | input | 2 | 01 flash, 10 ground loop, 00/11 unset (both) |
| redial_active | input | 1 | High while a redial is running; forces the long pulse |
| gl_out | output | 1 | Ground-loop output, high for the pulse duration |
| flash_out | output | 1 | Loop-break request, high for the flash duration |
| pause_start | output | 1 | One-cycle strobe that starts the post-recall pause |

## Verification
The assertions check these on every cycle: pause_start is a single-cycle strobe, it never overlaps either pulse, and no pulse is active during the pause. A flash only starts when MF mode was sampled. A ground-loop pulse only starts straight out of the hold phase. A timer is never restarted while it is running, and a timer only ends on a tick. The exact pulse lengths of 500, 1250, 100 and 3000 ticks, the 540/541 hold boundary, the redial override and the rejection of repeated or held presses depend on whole sequences. Only the bench's scenarios can show them, checked against its cycle model and its counted tick totals.

// File: rtl/recall_pkg.sv
package recall_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_HOLD  = 2'd1,
        PH_PULSE = 2'd2,
        PH_PAUSE = 2'd3
    } phase_t;

    localparam logic [1:0] CFG_FLASH_ONLY  = 2'b01;
    localparam logic [1:0] CFG_GROUND_ONLY = 2'b10;

    typedef struct packed {
        phase_t phase;
        logic   key_prev;
        logic   pause_pulse;
    } ctrl_state_t;

endpackage

// File: rtl/recall_hold_meter.sv
module recall_hold_meter #(
    parameter int HOLD_LIMIT = 540
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic count_i,
    output logic long_o
);
    localparam int SAT   = HOLD_LIMIT + 1;
    localparam int CNT_W = $clog2(SAT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (count_i && (cnt_q < CNT_W'(SAT))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign long_o = (cnt_q > CNT_W'(HOLD_LIMIT));

    AST_METER_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SAT)); // R2

    AST_METER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !long_o); // R1

endmodule

// File: rtl/recall_span_timer.sv
module recall_span_timer #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             tick_i,
    output logic             active_o
);
    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] remain;
    } span_t;

    span_t span_d, span_q;

    always_comb begin
        span_d = span_q;
        if (start_i) begin
            span_d.active = 1'b1;
            span_d.remain = len_i;
        end else if (span_q.active && tick_i) begin
            if (span_q.remain <= LEN_W'(1)) begin
                span_d.active = 1'b0;
                span_d.remain = '0;
            end else begin
                span_d.remain = span_q.remain - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q <= '0;
        end else begin
            span_q <= span_d;
        end
    end

    assign active_o = span_q.active;

    AST_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> $past(tick_i)); // R7

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !span_q.active); // R8

endmodule

// File: rtl/recall_signal_gen.sv
module recall_signal_gen #(
    parameter int HOLD_LIMIT_MS = 540,
    parameter int SHORT_GL_MS   = 500,
    parameter int LONG_GL_MS    = 1250,
    parameter int FLASH_MS      = 100,
    parameter int PAUSE_MS      = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       recall_key,
    input  logic       mode_mf,
    input  logic [1:0] recall_cfg,
    input  logic       redial_active,
    output logic       gl_out,
    output logic       flash_out,
    output logic       pause_start
);
    import recall_pkg::*;

    localparam int MAX_A   = (LONG_GL_MS > SHORT_GL_MS) ? LONG_GL_MS : SHORT_GL_MS;
    localparam int MAX_B   = (PAUSE_MS > FLASH_MS) ? PAUSE_MS : FLASH_MS;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    ctrl_state_t st_d, st_q;

    logic             held_long;
    logic             meter_clear, meter_count;
    logic             start_gl, start_fl, start_ps;
    logic             gl_active, fl_active, ps_active;
    logic             want_gl, want_fl, use_long;
    logic [LEN_W-1:0] gl_len;

    always_comb begin
        want_gl = (recall_cfg != CFG_FLASH_ONLY);
        want_fl = (recall_cfg != CFG_GROUND_ONLY) && mode_mf;
        use_long = held_long || redial_active;
        gl_len  = use_long ? LEN_W'(LONG_GL_MS) : LEN_W'(SHORT_GL_MS);
    end

    always_comb begin
        st_d             = st_q;
        st_d.key_prev    = recall_key;
        st_d.pause_pulse = 1'b0;
        meter_clear      = 1'b0;
        start_gl         = 1'b0;
        start_fl         = 1'b0;
        start_ps         = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (recall_key && !st_q.key_prev) begin
                    meter_clear = 1'b1;
                    st_d.phase  = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (held_long || !recall_key) begin
                    start_gl   = want_gl;
                    start_fl   = want_fl;
                    st_d.phase = PH_PULSE;
                end
            end
            PH_PULSE: begin
                if (!gl_active && !fl_active) begin
                    start_ps         = 1'b1;
                    st_d.pause_pulse = 1'b1;
                    st_d.phase       = PH_PAUSE;
                end
            end
            PH_PAUSE: begin
                if (!ps_active) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, key_prev: 1'b0, pause_pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign meter_count = (st_q.phase == PH_HOLD) && recall_key && ms_tick;

    recall_hold_meter #(
        .HOLD_LIMIT(HOLD_LIMIT_MS)
    ) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(meter_clear),
        .count_i(meter_count),
        .long_o (held_long)
    );

    recall_span_timer #(.LEN_W(LEN_W)) u_gl_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_gl),
        .len_i   (gl_len),
        .tick_i  (ms_tick),
        .active_o(gl_active)
    );

    recall_span_timer #(.LEN_W(LEN_W)) u_flash_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_fl),
        .len_i   (LEN_W'(FLASH_MS)),
        .tick_i  (ms_tick),
        .active_o(fl_active)
    );

    recall_span_timer #(.LEN_W(LEN_W)) u_pause_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_ps),
        .len_i   (LEN_W'(PAUSE_MS)),
        .tick_i  (ms_tick),
        .active_o(ps_active)
    );

    assign gl_out      = gl_active;
    assign flash_out   = fl_active;
    assign pause_start = st_q.pause_pulse;

    AST_PAUSE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        pause_start |=> !pause_start); // R6

    AST_PAUSE_AFTER_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        pause_start |-> (!gl_out && !flash_out)); // R6

    AST_QUIET_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_PAUSE) |-> (!gl_out && !flash_out)); // R8

    AST_FLASH_ONLY_MF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_out) |-> $past(mode_mf)); // R5

    AST_GL_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gl_out) |-> $past(st_q.phase == PH_HOLD)); // R1

endmodule

// File: tb/recall_signal_gen_bench.sv
module recall_signal_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       recall_key = 1'b0;
    logic       mode_mf = 1'b1;
    logic [1:0] recall_cfg = 2'b00;
    logic       redial_active = 1'b0;
    logic       gl_out, flash_out, pause_start;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic key_lvl = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_phase = 0, m_hold = 0, m_gl = 0, m_fl = 0, m_ps = 0;
    bit m_psflag = 1'b0, m_pkey = 1'b0;

    // per-scenario counters
    int gl_ticks = 0, fl_ticks = 0, ps_cnt = 0;

    always #5 clk = ~clk;

    recall_signal_gen u_recall_signal_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_tick      (ms_tick),
        .recall_key   (recall_key),
        .mode_mf      (mode_mf),
        .recall_cfg   (recall_cfg),
        .redial_active(redial_active),
        .gl_out       (gl_out),
        .flash_out    (flash_out),
        .pause_start  (pause_start)
    );

    always @(posedge clk) begin
        int o_gl, o_fl, o_ps;
        bit lng;
        cycles++;
        if (!rst_n) begin
            m_phase = 0; m_hold = 0; m_gl = 0; m_fl = 0; m_ps = 0;
            m_psflag = 1'b0; m_pkey = 1'b0;
        end else begin
            o_gl = m_gl; o_fl = m_fl; o_ps = m_ps;
            m_psflag = 1'b0;
            if (o_gl > 0 && ms_tick) m_gl--;
            if (o_fl > 0 && ms_tick) m_fl--;
            if (o_ps > 0 && ms_tick) m_ps--;
            case (m_phase)
                0: if (recall_key && !m_pkey) begin m_phase = 1; m_hold = 0; end
                1: begin
                    if (m_hold >= 541 || !recall_key) begin
                        lng = (m_hold >= 541) || redial_active;
                        if (recall_cfg != 2'b01) m_gl = lng ? 1250 : 500;
                        if (recall_cfg != 2'b10 && mode_mf) m_fl = 100;
                        m_phase = 2;
                    end else if (ms_tick) begin
                        m_hold++;
                    end
                end
                2: if (o_gl == 0 && o_fl == 0) begin
                    m_ps = 3000; m_psflag = 1'b1; m_phase = 3;
                end
                default: if (o_ps == 0) m_phase = 0;
            endcase
            m_pkey = recall_key;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (rst_n) begin
            chk(gl_out == (m_gl > 0), "R1 R2 R3 gl_out per cycle", gl_out, m_gl > 0);
            chk(flash_out == (m_fl > 0), "R7 flash_out per cycle", flash_out, m_fl > 0);
            chk(pause_start == m_psflag, "R6 pause_start per cycle", pause_start, m_psflag);
        end
        ms_tick    = ~ms_tick;
        recall_key = key_lvl;
        if (gl_out && ms_tick) gl_ticks++;
        if (flash_out && ms_tick) fl_ticks++;
        if (pause_start) ps_cnt++;
    endtask

    task automatic clear_counts();
        gl_ticks = 0; fl_ticks = 0; ps_cnt = 0;
    endtask

    task automatic hold_key(input int n);
        int seen = 0;
        key_lvl = 1'b1;
        step();
        while (seen < n) begin
            step();
            if (ms_tick) seen++;
        end
        key_lvl = 1'b0;
        step();
    endtask

    task automatic wait_idle();
        step();
        while (m_phase != 0) step();
        step();
    endtask

    task automatic recall(input int n);
        clear_counts();
        hold_key(n);
        wait_idle();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        while (!done && cycles < 190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!gl_out && !flash_out && !pause_start, "R9 outputs in reset", {gl_out, flash_out, pause_start}, 0);
        rst_n = 1'b1;
        step();
        chk(!gl_out && !flash_out && !pause_start, "R9 outputs after reset", {gl_out, flash_out, pause_start}, 0);

        // R1 R4 R7 R6: MF, unset config, short hold
        mode_mf = 1'b1; recall_cfg = 2'b00;
        recall(200);
        chk(gl_ticks == 500, "R1 short pulse length", gl_ticks, 500);
        chk(fl_ticks == 100, "R7 flash length (R4 unset)", fl_ticks, 100);
        chk(ps_cnt == 1, "R6 one pause strobe", ps_cnt, 1);

        // R2: ground loop only, long hold
        recall_cfg = 2'b10;
        recall(700);
        chk(gl_ticks == 1250, "R2 long pulse length", gl_ticks, 1250);
        chk(fl_ticks == 0, "R4 ground-only no flash", fl_ticks, 0);

        // R5: LD, unset config
        mode_mf = 1'b0; recall_cfg = 2'b11;
        recall(100);
        chk(fl_ticks == 0, "R5 no flash in LD", fl_ticks, 0);
        chk(gl_ticks == 500, "R4 unset gives ground loop", gl_ticks, 500);

        // R5: LD, flash-only config gives nothing but the pause
        recall_cfg = 2'b01;
        recall(50);
        chk(fl_ticks == 0 && gl_ticks == 0, "R5 flash-only in LD silent", fl_ticks + gl_ticks, 0);
        chk(ps_cnt == 1, "R6 pause still follows", ps_cnt, 1);

        // R4 R7: MF, flash-only
        mode_mf = 1'b1;
        recall(30);
        chk(fl_ticks == 100, "R7 flash-only length", fl_ticks, 100);
        chk(gl_ticks == 0, "R4 flash-only no ground loop", gl_ticks, 0);

        // R3: redial forces long
        recall_cfg = 2'b10; redial_active = 1'b1;
        recall(100);
        chk(gl_ticks == 1250, "R3 redial long pulse", gl_ticks, 1250);
        redial_active = 1'b0;

        // R1 R2 boundary
        recall(540);
        chk(gl_ticks == 500, "R1 hold of 540 is short", gl_ticks, 500);
        recall(541);
        chk(gl_ticks == 1250, "R2 hold of 541 is long", gl_ticks, 1250);

        // R8: repeated press during pulse, key still held after pause ends
        recall_cfg = 2'b00;
        clear_counts();
        hold_key(100);
        repeat (60) step();
        key_lvl = 1'b1;
        repeat (300) step();
        while (m_phase != 0) step();
        repeat (1500) step();
        chk(ps_cnt == 1, "R8 extra presses ignored", ps_cnt, 1);
        chk(gl_ticks == 500, "R8 pulse unchanged by extra press", gl_ticks, 500);
        chk(!gl_out && !flash_out, "R8 held key starts nothing", {gl_out, flash_out}, 0);
        key_lvl = 1'b0;
        repeat (4) step();
        recall(10);
        chk(ps_cnt == 1 && gl_ticks == 500, "R8 fresh press accepted", ps_cnt, 1);

        done = 1'b1;
        finish_run();
    end

endmodule